// File: doc/BRIEF.md
# Programmable Input Glitch Filter

A bank of per-line digital deglitchers for asynchronous pad inputs. Each raw input passes through a two-flop synchroniser. The filtered level then changes only after the synchronised value has differed from it without a break for a programmable window. Each line has two 4-bit fields. The select field sets a power-of-two prescale of the clock. The count field sets how many prescaled ticks the new value must last. The window is therefore count × 2^select clock cycles. Two small fields cover windows from one cycle up to about 15 × 2^15 cycles without one long counter per line.

A count of zero bypasses the filter, and the synchronised input then drives the output directly. The filtered levels feed the data-read and interrupt logic of a general-purpose I/O block. Software converts a time value into field settings. A setting of select 4 and count 9 gives a 144-cycle window, which is about 360 ns at a 2.5 ns clock.

Top module: `glf_top`

## Requirements
- R1: While rst_ni is low, and after reset is released, every filt_o bit is 0 until an input change has passed its filter.
- R2: Line n owns cfg_i[12n+11:12n]. The count is at bits 7:4 of that slice and the select at bits 11:8. Bits 3:0 are ignored.
- R3: With count 0, filt_o follows pin_i on the 3rd rising clock edge after pin_i changes (two synchroniser stages, then the output register).
- R4: With count C > 0 and select S, a clean change of pin_i shows on filt_o at rising edge C·2^S + 2 after the change.
- R5: A pulse that is shorter than C·2^S clock cycles leaves filt_o unchanged. A pulse of exactly C·2^S cycles is passed.
- R6: When the synchronised input returns to the filtered level, the window restarts. A later change then needs the full C·2^S cycles again.
- R7: Lines are independent. Activity on one line's input leaves the other lines' outputs unchanged.
- R8: With select 4 and count 9, the window is 144 cycles (latency 146 edges).
- R9: filt_o only ever takes the value that the synchronised input held on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | LINES | Raw asynchronous pad inputs |
| cfg_i | input | LINES*12 | Per-line filter fields (count 7:4, select 11:8) |
| filt_o | output | LINES | Filtered input levels |

## Verification
The assertions check on every cycle that the output moves only to the previously synchronised value, and that it moves only on a prescaler tick when the filter is active. They also check that bypass mode tracks the synchroniser and that the stability counter clears whenever no change is pending. Only the bench scenarios can show the exact latency for each field setting, the pass/reject boundary at a pulse of exactly one window, and the full restart of the window after a glitch. The same holds for the field positions, for the ignored low bits and for line independence.

// File: rtl/glf_pkg.sv
`timescale 1ns/1ps
package glf_pkg;
  localparam int CNT_W   = 4;
  localparam int SEL_W   = 4;
  localparam int RSV_W   = 4;
  localparam int CNT_LSB = RSV_W;
  localparam int SEL_LSB = CNT_LSB + CNT_W;
  localparam int CFG_W   = SEL_LSB + SEL_W;
  localparam int PRE_W   = (1 << SEL_W) - 1;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt;
  } glf_cfg_t;
endpackage

// File: rtl/glf_sync.sv
`timescale 1ns/1ps
module glf_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/glf_prescale.sv
`timescale 1ns/1ps
module glf_prescale import glf_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  // 2^sel - 1; wraps to all ones for the largest select
  assign mask   = (PRE_W'(1) << sel_i) - PRE_W'(1);
  assign tick_o = run_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/glf_line.sv
`timescale 1ns/1ps
module glf_line import glf_pkg::*; (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sync_i,
  input  glf_cfg_t cfg_i,
  output logic     filt_o
);
  logic             filt_q;
  logic [CNT_W-1:0] stab_q;
  logic             bypass, pend, run, tick, done;

  assign bypass = (cfg_i.cnt == '0);
  assign pend   = (sync_i != filt_q);
  assign run    = pend && !bypass;

  glf_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sel_i  (cfg_i.sel),
    .tick_o (tick)
  );

  assign done = tick && (stab_q >= (cfg_i.cnt - CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      stab_q <= '0;
    end else if (bypass) begin
      filt_q <= sync_i;
      stab_q <= '0;
    end else if (!pend) begin
      stab_q <= '0;  // restart window
    end else if (done) begin
      filt_q <= sync_i;
      stab_q <= '0;
    end else if (tick) begin
      stab_q <= stab_q + CNT_W'(1);
    end
  end

  assign filt_o = filt_q;

  // R9
  follow_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> filt_q == $past(sync_i));

  // R3
  bypass_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |=> filt_q == $past(sync_i));

  // R4
  tick_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && !tick) |=> $stable(filt_q));

  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend |=> stab_q == '0);
endmodule

// File: rtl/glf_top.sv
`timescale 1ns/1ps
module glf_top import glf_pkg::*; #(
  parameter int LINES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LINES-1:0]       pin_i,
  input  logic [LINES*CFG_W-1:0] cfg_i,
  output logic [LINES-1:0]       filt_o
);
  logic [LINES-1:0]       sync;
  logic [LINES*RSV_W-1:0] cfg_unused;

  glf_sync #(.W(LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    glf_cfg_t cfg_l;
    assign cfg_l.cnt = cfg_i[i*CFG_W+CNT_LSB +: CNT_W];
    assign cfg_l.sel = cfg_i[i*CFG_W+SEL_LSB +: SEL_W];
    assign cfg_unused[i*RSV_W +: RSV_W] = cfg_i[i*CFG_W +: RSV_W];

    glf_line u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (sync[i]),
      .cfg_i  (cfg_l),
      .filt_o (filt_o[i])
    );
  end
endmodule

// File: tb/tb_glf_top.sv
`timescale 1ns/1ps
module tb_glf_top;
  localparam int LINES = 4;
  localparam int CW    = 12;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic [LINES-1:0]    pin = '0;
  logic [LINES*CW-1:0] cfg = '0;
  logic [LINES-1:0]    filt;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  glf_top #(.LINES(LINES)) dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .pin_i  (pin),
    .cfg_i  (cfg),
    .filt_o (filt)
  );

  // {select, count}
  localparam logic [7:0] VEC [9] = '{
    8'h00, 8'h01, 8'h05, 8'h13, 8'h31, 8'h2F, 8'h37, 8'h49, 8'h52
  };

  function automatic int win(input int s, input int c);
    return c * (1 << s);
  endfunction

  function automatic int lat(input int s, input int c);
    return (c == 0) ? 3 : win(s, c) + 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int l, input int s, input int c, input int rsv);
    cfg[l*CW +: CW] = {4'(s), 4'(c), 4'(rsv)};
  endtask

  // drive a clean change on line l, count edges until filt follows
  task automatic measure(input int l, input logic v, input int exp, input string req);
    logic [LINES-1:0] other;
    int got;
    got = -1;
    @(negedge clk);
    other = filt;
    pin[l] = v;
    for (int k = 1; k <= exp + 20; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (filt[l] == v) begin
        got = k;
        break;
      end
    end
    chk(req, got, exp);
    other[l] = filt[l];
    chk("R7", int'(filt), int'(other));
  endtask

  // pulse of w cycles on line l; report whether filt ever took v
  task automatic pulse(input int l, input logic v, input int w, input int n,
                       input int exp_seen, input string req);
    int seen;
    seen = 0;
    @(negedge clk);
    pin[l] = v;
    for (int k = 1; k <= w + n + 8; k++) begin
      @(negedge clk);
      if (k == w) pin[l] = ~v;
      if (filt[l] == v) seen = 1;
    end
    repeat (n + 8) @(negedge clk);
    chk(req, seen, exp_seen);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int l = 0; l < LINES; l++) set_cfg(l, 0, 0, 15);
    pin = '1;
    repeat (3) @(negedge clk);
    chk("R1", int'(filt), 0);        // held in reset with pins high
    rst_ni = 1'b1;
    @(negedge clk);
    pin = '0;
    repeat (4) @(negedge clk);
    chk("R1", int'(filt), 0);

    // table walk on line 0; low nibble of cfg set to junk (R2)
    foreach (VEC[i]) begin
      int s, c;
      s = int'(VEC[i][7:4]);
      c = int'(VEC[i][3:0]);
      set_cfg(0, s, c, 4'hB);
      repeat (2) @(negedge clk);
      measure(0, 1'b1, lat(s, c), (c == 0) ? "R3" : "R2/R4");
      measure(0, 1'b0, lat(s, c), (c == 0) ? "R3" : "R2/R4");
    end

    // R8: select 4, count 9
    set_cfg(1, 4, 9, 0);
    measure(1, 1'b1, 146, "R8");
    measure(1, 1'b0, 146, "R8");

    // R5: pulse boundary, select 1 count 3 -> window 6
    set_cfg(1, 1, 3, 0);
    repeat (2) @(negedge clk);
    pulse(1, 1'b1, 5, 6, 0, "R5");
    chk("R5", int'(filt[1]), 0);
    pulse(1, 1'b1, 6, 6, 1, "R5");
    chk("R5", int'(filt[1]), 0);

    // R6: glitch back to filtered level restarts the window
    set_cfg(2, 0, 4, 0);
    repeat (2) @(negedge clk);
    pin[2] = 1'b1;
    repeat (3) @(negedge clk);
    pin[2] = 1'b0;
    @(negedge clk);
    chk("R6", int'(filt[2]), 0);
    measure(2, 1'b1, 6, "R6");

    // R1: reset mid-run clears outputs
    @(negedge clk);
    chk("R1", int'(filt[2]), 1);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", int'(filt), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule